// File: doc/BRIEF.md
# PCM Sample Word Packer with Buffer Sequencer

This block sits between an audio decimator and a memory write port. It takes 16-bit left/right PCM sample pairs, packs them two halves to a 32-bit word, and hands each word to a valid/ready write interface. Addresses start at a buffer pointer and step by one word each time. A transfer ends when a programmed number of samples has been stored, or when software asks it to stop.

Software begins a transfer with a start pulse and can end it early with a stop pulse. Three sticky event flags report the transfer's progress: started, stopped and end. Each flag has an interrupt enable, and the enabled flags are ORed onto one interrupt line. Two packing modes are available. Stereo puts one pair in each word. Mono puts two successive left samples in each word.

Top module: `pcm_word_packer`

## Requirements
- R1: After reset, all event flags, the interrupt enable mask, `irq`, `wr_valid` and `overflow` are zero.
- R2: A start pulse while idle does four things. It latches `cfg_ptr`, `cfg_count` and `cfg_mono`. It clears `overflow`. It sets the STARTED flag (`evt_flags[0]`) on that clock edge. It makes the first word go to the latched pointer.
- R3: In stereo mode (`cfg_mono`=0), each word holds left in bits 15:0 and right in bits 31:16. A count of N yields N words. Word i is written at pointer+4*i. While `wr_valid` is high and `wr_ready` is low, the data and address are held.
- R4: In mono mode (`cfg_mono`=1), each word holds two successive left samples, the earlier one in bits 15:0. Right-channel data has no effect. A count of N yields ceil(N/2) words. A trailing half word is written with zero in bits 31:16.
- R5: Once the sample that reaches the count is accepted, no more samples are taken. The END flag (`evt_flags[2]`) sets after the last word is written. STOPPED is not raised unless a stop was requested.
- R6: A stop pulse while running works as follows. A sample presented in the same cycle is still accepted, and later samples are ignored. Any half-filled mono word is flushed with a zero upper half. END sets once all words are written, and STOPPED (`evt_flags[1]`) sets exactly one cycle after END.
- R7: Bits of `ien_set` enable and bits of `ien_clr` disable the matching interrupt. Clear wins when both are given. `ien_mask` shows the enables, and `irq` is high whenever a set flag is enabled.
- R8: Event flags stay set until the matching `evt_clr` bit is pulsed. A flag being set in the same cycle wins over its clear.
- R9: A sample is dropped and `overflow` is set when it needs a word slot and two conditions hold together: the staged word is stalled (`wr_valid`=1, `wr_ready`=0) and a new word must be staged. A dropped sample does not count toward the limit, and `overflow` stays set until the next start.
- R10: Changing `cfg_ptr`, `cfg_count` or `cfg_mono` during a transfer does not affect that transfer.
- R11: A start pulse while running is ignored, and a stop pulse while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mono | input | 1 | 1 = mono packing, 0 = stereo |
| cfg_ptr | input | AW | Buffer start address |
| cfg_count | input | CW | Samples per buffer |
| task_start | input | 1 | Start pulse |
| task_stop | input | 1 | Stop pulse |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | SW | Left sample |
| smp_right | input | SW | Right sample |
| wr_valid | output | 1 | Word write request |
| wr_addr | output | AW | Word address |
| wr_data | output | 2*SW | Packed word |
| wr_ready | input | 1 | Write port accepts word |
| evt_clr | input | 3 | Clear pulses for event flags |
| evt_flags | output | 3 | {END, STOPPED, STARTED} |
| ien_set | input | 3 | Interrupt enable set bits |
| ien_clr | input | 3 | Interrupt enable clear bits |
| ien_mask | output | 3 | Current interrupt enables |
| irq | output | 1 | Combined interrupt |
| overflow | output | 1 | Sticky sample-drop flag |

## Verification
A stop request can arrive in the same cycle as the sample that reaches the count. In that case the count-limit end and the stop-driven end coincide. The bench provokes this by pulsing stop together with the final sample of a buffer. It judges the result by three things: the exact word list, END appearing once, and STOPPED rising exactly one cycle after END. A second collision is a flag set and its clear pulse in one cycle. The bench drives a start together with a STARTED clear and expects the flag to remain set.

// File: rtl/pcm_word_packer.sv
module pcm_word_packer #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mono,
  input  logic [AW-1:0] cfg_ptr,
  input  logic [CW-1:0] cfg_count,
  input  logic          task_start,
  input  logic          task_stop,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [2*SW-1:0] wr_data,
  input  logic          wr_ready,
  input  logic [2:0]    evt_clr,
  output logic [2:0]    evt_flags,
  input  logic [2:0]    ien_set,
  input  logic [2:0]    ien_clr,
  output logic [2:0]    ien_mask,
  output logic          irq,
  output logic          overflow
);
  localparam int WW = 2 * SW;
  localparam logic [AW-1:0] STEP = AW'(WW / 8);

  logic          running, drain, stop_req, stop_pend, mono_q, half;
  logic [CW-1:0] lim_q, taken;
  logic [SW-1:0] low;

  logic slot_free, accept_req, need_push, drop, take, last_smp;
  logic push_smp, push_flush, push, done, start_go;
  logic [WW-1:0] push_word;

  assign start_go   = task_start && !running;
  assign slot_free  = !wr_valid || wr_ready;
  assign accept_req = running && !drain && smp_valid;
  assign need_push  = !mono_q || half;
  assign drop       = accept_req && need_push && !slot_free;
  assign take       = accept_req && !drop;
  assign last_smp   = take && (taken + 1'b1 == lim_q);
  assign push_smp   = take && need_push;
  assign push_flush = running && drain && half && slot_free;
  assign push       = push_smp || push_flush;
  assign done       = running && drain && !half && !wr_valid;
  assign push_word  = push_flush ? {{SW{1'b0}}, low} :
                      mono_q     ? {smp_left, low}   : {smp_right, smp_left};
  assign irq        = |(evt_flags & ien_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      drain    <= 1'b0;
      stop_req <= 1'b0;
      stop_pend <= 1'b0;
      mono_q   <= 1'b0;
      half     <= 1'b0;
      lim_q    <= '0;
      taken    <= '0;
      low      <= '0;
      wr_addr  <= '0;
      overflow <= 1'b0;
    end else begin
      stop_pend <= 1'b0;
      if (start_go) begin
        running  <= 1'b1;
        drain    <= 1'b0;
        stop_req <= 1'b0;
        mono_q   <= cfg_mono;
        lim_q    <= cfg_count;
        taken    <= '0;
        half     <= 1'b0;
        wr_addr  <= cfg_ptr;
        overflow <= 1'b0;
      end else if (running) begin
        if (wr_valid && wr_ready) wr_addr <= wr_addr + STEP;
        if (take) begin
          taken <= taken + 1'b1;
          if (mono_q && !half) begin
            low  <= smp_left;
            half <= 1'b1;
          end else begin
            half <= 1'b0;
          end
        end
        if (push_flush) half <= 1'b0;
        if (last_smp || task_stop) drain <= 1'b1;
        if (task_stop) stop_req <= 1'b1;
        if (drop) overflow <= 1'b1;
        if (done) begin
          running   <= 1'b0;
          stop_pend <= stop_req || task_stop;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (push) begin
      wr_valid <= 1'b1;
      wr_data  <= push_word;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_flags <= '0;
      ien_mask  <= '0;
    end else begin
      evt_flags <= (evt_flags & ~evt_clr) | {done, stop_pend, start_go};
      ien_mask  <= (ien_mask | ien_set) & ~ien_clr;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));

  p_stop_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flags[1]) |-> $past(evt_flags[2]));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !wr_valid);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_valid && !wr_ready));

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flags != 3'b000));
endmodule

// File: tb/pcm_word_packer_test.sv
module pcm_word_packer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_mono = 1'b0;
  logic [31:0] cfg_ptr = '0;
  logic [15:0] cfg_count = '0;
  logic task_start = 1'b0, task_stop = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic wr_valid, wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data;
  logic [2:0] evt_clr = '0, evt_flags, ien_set = '0, ien_clr = '0, ien_mask;
  logic irq, overflow;

  int tests = 0, fails = 0, nw = 0;
  bit finished = 0;
  logic [31:0] got_d [0:255];
  logic [31:0] got_a [0:255];

  localparam logic [23:0] CASES [8] = '{
    {8'd0, 8'd4, 8'd0}, {8'd1, 8'd4, 8'd0}, {8'd1, 8'd5, 8'd0}, {8'd0, 8'd6, 8'd3},
    {8'd1, 8'd6, 8'd3}, {8'd1, 8'd6, 8'd4}, {8'd0, 8'd3, 8'd3}, {8'd1, 8'd1, 8'd0}};

  pcm_word_packer uut (.*);

  always #2 clk = ~clk;

  always @(negedge clk)
    if (rst_n && wr_valid && wr_ready && nw < 256) begin
      got_d[nw] = wr_data;
      got_a[nw] = wr_addr;
      nw = nw + 1;
    end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic pulse_start;
    task_start = 1'b1; tick; task_start = 1'b0;
  endtask

  task automatic send(input logic [15:0] l, input logic [15:0] r, input logic stp);
    smp_valid = 1'b1; smp_left = l; smp_right = r; task_stop = stp;
    tick;
    smp_valid = 1'b0; task_stop = 1'b0;
  endtask

  task automatic clear_flags;
    evt_clr = 3'b111; tick; evt_clr = 3'b000;
  endtask

  task automatic wait_end;
    for (int t = 0; t < 100 && !evt_flags[2]; t++) tick;
  endtask

  function automatic logic [15:0] lval(input int c, input int k);
    return 16'h1000 + 16'(c << 8) + 16'(k);
  endfunction
  function automatic logic [15:0] rval(input int c, input int k);
    return 16'h9000 + 16'(c << 8) + 16'(k);
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    chk("R1 flags", 64'(evt_flags), 0);
    chk("R1 mask", 64'(ien_mask), 0);
    chk("R1 irq/valid/ovf", {irq, wr_valid, overflow}, 0);
    rst_n = 1'b1; tick;

    task_stop = 1'b1; tick; task_stop = 1'b0;
    repeat (4) tick;
    chk("R11 stop while idle", 64'(evt_flags), 0);

    for (int c = 0; c < 8; c++) begin
      automatic int mono = int'(CASES[c][23:16]);
      automatic int cnt = int'(CASES[c][15:8]);
      automatic int nstop = int'(CASES[c][7:0]);
      automatic int s = (nstop != 0 && nstop < cnt) ? nstop : cnt;
      automatic int w = mono != 0 ? (s + 1) / 2 : s;
      automatic int base;
      automatic int e = -1, st = -1;
      automatic logic [31:0] ptr = 32'h2000_0000 + 32'(c * 256);
      cfg_mono = mono[0]; cfg_count = 16'(cnt); cfg_ptr = ptr;
      base = nw;
      pulse_start;
      chk($sformatf("R2 started case %0d", c), 64'(evt_flags[0]), 1);
      for (int k = 0; k < s + 2; k++)
        send(lval(c, k), rval(c, k), (nstop != 0 && k == s - 1));
      for (int t = 0; t < 100; t++) begin
        if (evt_flags[2] && e < 0) e = t;
        if (evt_flags[1] && st < 0) st = t;
        tick;
      end
      chk($sformatf("R5 end case %0d", c), 64'(e >= 0), 1);
      if (nstop != 0) chk($sformatf("R6 stopped after end case %0d", c), 64'(st), 64'(e + 1));
      else chk($sformatf("R5 no stopped case %0d", c), 64'(st), 64'(-1));
      chk($sformatf("R3 R4 word count case %0d", c), 64'(nw - base), 64'(w));
      for (int i = 0; i < w; i++) begin
        automatic logic [31:0] ex;
        if (mono == 0) ex = {rval(c, i), lval(c, i)};
        else ex = {(2 * i + 1 < s) ? lval(c, 2 * i + 1) : 16'h0000, lval(c, 2 * i)};
        chk($sformatf("R3 R4 R6 data case %0d word %0d", c, i), 64'(got_d[base + i]), 64'(ex));
        chk($sformatf("R3 addr case %0d word %0d", c, i), 64'(got_a[base + i]), 64'(ptr + 32'(4 * i)));
      end
      clear_flags;
    end

    ien_set = 3'b101; tick; ien_set = 3'b000;
    chk("R7 mask set", 64'(ien_mask), 64'(3'b101));
    ien_set = 3'b010; ien_clr = 3'b010; tick; ien_set = 3'b000; ien_clr = 3'b000;
    chk("R7 clear wins", 64'(ien_mask), 64'(3'b101));
    chk("R7 irq low", 64'(irq), 0);
    cfg_mono = 1'b0; cfg_count = 16'd1; cfg_ptr = 32'h3000_0000;
    pulse_start;
    chk("R7 irq on started", 64'(irq), 1);
    send(16'h0001, 16'h0002, 1'b0);
    wait_end;
    ien_clr = 3'b001; tick; ien_clr = 3'b000;
    chk("R7 irq from end", 64'(irq), 1);
    evt_clr = 3'b100; tick; evt_clr = 3'b000;
    chk("R7 irq dropped", 64'(irq), 0);
    clear_flags;

    cfg_count = 16'd2;
    evt_clr = 3'b001; task_start = 1'b1; tick; evt_clr = 3'b000; task_start = 1'b0;
    chk("R8 set wins over clear", 64'(evt_flags[0]), 1);
    repeat (5) tick;
    chk("R8 sticky", 64'(evt_flags[0]), 1);
    send(16'h0003, 16'h0004, 1'b0); send(16'h0005, 16'h0006, 1'b0);
    wait_end; tick;
    clear_flags;

    begin
      automatic int base = nw;
      cfg_mono = 1'b0; cfg_count = 16'd4; cfg_ptr = 32'h4000_0000;
      wr_ready = 1'b0;
      pulse_start;
      cfg_ptr = 32'h5000_0000; cfg_count = 16'd1; cfg_mono = 1'b1;
      send(16'hA000, 16'hB000, 1'b0);
      send(16'hA001, 16'hB001, 1'b0);
      chk("R9 overflow set", 64'(overflow), 1);
      pulse_start;
      chk("R11 start while running ignored", 64'(overflow), 1);
      chk("R10 addr held", 64'(wr_addr), 64'(32'h4000_0000));
      wr_ready = 1'b1;
      send(16'hA002, 16'hB002, 1'b0);
      send(16'hA003, 16'hB003, 1'b0);
      send(16'hA004, 16'hB004, 1'b0);
      wait_end; tick;
      chk("R9 R10 word count", 64'(nw - base), 4);
      chk("R9 dropped sample skipped", 64'(got_d[base + 1]), 64'(32'hB002_A002));
      chk("R10 last word", 64'(got_d[base + 3]), 64'(32'hB004_A004));
      chk("R10 last addr", 64'(got_a[base + 3]), 64'(32'h4000_000C));
      clear_flags;
      cfg_mono = 1'b0; cfg_count = 16'd1;
      pulse_start;
      chk("R2 start clears overflow", 64'(overflow), 0);
      send(16'h0007, 16'h0008, 1'b0);
      wait_end; tick;
      clear_flags;
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule